// File: doc/BRIEF.md
# ECC-Protected Two-Port Memory Wrapper

This block is a 32-word memory with one write port and one read port, each word carrying 119 bits of data. On every write, a single-error-correcting Hamming code of 7 check bits is computed over the data. The 126-bit protected word is then laid across two physical 64-bit storage banks at the same address, in the same cycle. On every read, both banks are read, the check bits are recomputed and compared with the stored ones, a single flipped bit is repaired, and the outcome is reported on three flags.

The code word has 126 positions numbered 1 to 126. Check bit k sits at position 2^k. The data bits fill the remaining positions in ascending order, so data bit 0 is at position 3 and data bit 118 is at position 126. There is no extra overall parity bit, so double-bit errors are not told apart from single-bit ones. Some multi-bit patterns are still flagged as uncorrectable, and others are silently miscorrected.

The storage banks are plain synchronous arrays. A read returns its result one cycle after the request. If the same address is read and written in the same cycle, the read returns the word stored before that write.

Top module: `ecc_ram_wrapper`

## Requirements
- R1: While reset is asserted, and after its release until the first read, `rd_valid`, `err_alarm`, `err_fix` and `err_fatal` are all low.
- R2: `rd_valid` is high in exactly the cycle after each cycle with `rd_en` high, and low otherwise. Back-to-back reads each produce one result.
- R3: A word written and then read back without corruption returns the written data, with all three error flags low.
- R4: A read and a write to the same address in the same cycle return the word stored before that write. A later read returns the new word.
- R5: A single flipped bit at a data position of the stored word is corrected on read: `rd_data` equals the written data, and `err_fix` and `err_alarm` are high while `err_fatal` is low.
- R6: A single flipped check bit (code positions 1, 2, 4, 8, 16, 32, 64) leaves `rd_data` equal to the written data, with `err_fix` and `err_alarm` high.
- R7: Bits 62 and 63 of the upper bank are written as zero and are never read. Flipping them changes neither `rd_data` nor any flag.
- R8: A syndrome of 127, for example from flipping code positions 63 and 64 together, raises `err_fatal` and `err_alarm` with `err_fix` low. The data is passed through uncorrected.
- R9: A double error whose syndrome falls in 1..126 is treated as a single error at that position. Flipping positions 3 and 5 gives a read with data bits 0, 1 and 2 inverted, with `err_fix` high.
- R10: The lower bank holds data bits 63:0. The upper bank holds data bits 118:64 in its bits 54:0, check bit k in bit 55+k, and zero in bits 63:62. A flip on either side of the bank boundary (data bits 63 and 64) is corrected.
- R11: With `wr_en` low, values on the write address and data ports leave the stored contents unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Write request |
| wr_addr | input | 5 | Write word address |
| wr_data | input | 119 | Write data |
| rd_en | input | 1 | Read request |
| rd_addr | input | 5 | Read word address |
| rd_data | output | 119 | Corrected read data, valid with `rd_valid` |
| rd_valid | output | 1 | Read result valid, one cycle after `rd_en` |
| err_alarm | output | 1 | Non-zero syndrome on the current result |
| err_fix | output | 1 | Syndrome in 1..126; single-bit repair applied |
| err_fatal | output | 1 | Syndrome 127; uncorrectable |

## Verification
The hardest situations to reach are the ones where a stored word no longer matches what was written. The write path always stores a consistent code word, so no sequence of port operations can produce a syndrome. The bench therefore writes a word through the ports and then, between the write and the read, inverts chosen bits directly in the bank arrays. It targets specific code positions through the stated bank layout: data bits on both sides of the bank boundary, check bits, padding bits, and pairs chosen to give syndrome 127 or a miscorrection. The expected data and flags are derived from the position numbering alone.

// File: rtl/ecc_ram_pkg.sv
package ecc_ram_pkg;

  localparam int unsigned ECC_DEPTH  = 32;
  localparam int unsigned ECC_DATA_W = 119;
  localparam int unsigned ECC_CHK_W  = 7;
  localparam int unsigned ECC_BANK_W = 64;

  typedef enum logic [1:0] {
    SYN_CLEAN = 2'd0,
    SYN_FIX   = 2'd1,
    SYN_FATAL = 2'd2
  } syn_class_e;

  // True for code positions reserved for check bits (powers of two).
  function automatic logic is_check_pos(input int p);
    return (p > 0) && ((p & (p - 1)) == 0);
  endfunction

endpackage

// File: rtl/ecc_ram_bank.sv
module ecc_ram_bank #(
  parameter int unsigned DEPTH  = 32,
  parameter int unsigned WIDTH  = 64,
  parameter int unsigned RD_W   = 64,
  localparam int unsigned AW    = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             rd_en,
  input  logic [AW-1:0]    rd_addr,
  output logic [RD_W-1:0]  rd_data
);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [RD_W-1:0]  rd_q;

  // Both ports sample on the same edge; nonblocking update gives read-before-write.
  always_ff @(posedge clk) begin
    if (wr_en) begin
      mem[wr_addr] <= wr_data;
    end
    if (rd_en) begin
      rd_q <= mem[rd_addr][RD_W-1:0];
    end
  end

  assign rd_data = rd_q;

endmodule

// File: rtl/ecc_ram_encoder.sv
module ecc_ram_encoder #(
  parameter int unsigned DATA_W = 119,
  parameter int unsigned CHK_W  = 7,
  localparam int unsigned CODE_N = DATA_W + CHK_W
) (
  input  logic [DATA_W-1:0] data,
  output logic [CHK_W-1:0]  chk
);
  import ecc_ram_pkg::*;

  // Check bit k: even parity over data at positions whose index has bit k set.
  always_comb begin
    int j;
    chk = '0;
    j   = 0;
    for (int p = 1; p <= int'(CODE_N); p++) begin
      if (!is_check_pos(p)) begin
        for (int k = 0; k < int'(CHK_W); k++) begin
          if (p[k]) begin
            chk[k] = chk[k] ^ data[j];
          end
        end
        j++;
      end
    end
  end

endmodule

// File: rtl/ecc_ram_decoder.sv
module ecc_ram_decoder #(
  parameter int unsigned DATA_W = 119,
  parameter int unsigned CHK_W  = 7,
  localparam int unsigned CODE_N = DATA_W + CHK_W
) (
  input  logic              valid,
  input  logic [DATA_W-1:0] raw_data,
  input  logic [CHK_W-1:0]  raw_chk,
  output logic [DATA_W-1:0] fixed_data,
  output logic              alarm,
  output logic              fix,
  output logic              fatal
);
  import ecc_ram_pkg::*;

  logic [CHK_W-1:0] calc_chk;
  logic [CHK_W-1:0] syndrome;
  syn_class_e       syn_class;

  ecc_ram_encoder #(
    .DATA_W (DATA_W),
    .CHK_W  (CHK_W)
  ) u_recalc (
    .data (raw_data),
    .chk  (calc_chk)
  );

  assign syndrome = raw_chk ^ calc_chk;

  always_comb begin
    if (syndrome == '0) begin
      syn_class = SYN_CLEAN;
    end else if (int'(syndrome) <= int'(CODE_N)) begin
      syn_class = SYN_FIX;
    end else begin
      syn_class = SYN_FATAL;
    end
  end

  // Flip the data bit whose code position equals the syndrome.
  always_comb begin
    int j;
    fixed_data = raw_data;
    j          = 0;
    for (int p = 1; p <= int'(CODE_N); p++) begin
      if (!is_check_pos(p)) begin
        if ((syn_class == SYN_FIX) && (int'(syndrome) == p)) begin
          fixed_data[j] = ~raw_data[j];
        end
        j++;
      end
    end
  end

  assign alarm = valid && (syn_class != SYN_CLEAN);
  assign fix   = valid && (syn_class == SYN_FIX);
  assign fatal = valid && (syn_class == SYN_FATAL);

endmodule

// File: rtl/ecc_ram_wrapper.sv
module ecc_ram_wrapper #(
  parameter int unsigned DEPTH  = ecc_ram_pkg::ECC_DEPTH,
  parameter int unsigned DATA_W = ecc_ram_pkg::ECC_DATA_W,
  parameter int unsigned CHK_W  = ecc_ram_pkg::ECC_CHK_W,
  parameter int unsigned BANK_W = ecc_ram_pkg::ECC_BANK_W,
  localparam int unsigned AW    = $clog2(DEPTH),
  localparam int unsigned HI_DW = DATA_W - BANK_W,
  localparam int unsigned HI_RD = HI_DW + CHK_W,
  localparam int unsigned PAD_W = BANK_W - HI_RD
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [AW-1:0]     rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  output logic              err_alarm,
  output logic              err_fix,
  output logic              err_fatal
);

  // Reset: asserted asynchronously, released after two clock edges.
  logic [1:0] rst_pipe_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe_q <= '0;
    end else begin
      rst_pipe_q <= {rst_pipe_q[0], 1'b1};
    end
  end
  assign rst_sync_n = rst_pipe_q[1];

  // Write path: encode, then pack across the two banks.
  logic [CHK_W-1:0]  wr_chk;
  logic [BANK_W-1:0] lo_wdata;
  logic [BANK_W-1:0] hi_wdata;

  ecc_ram_encoder #(
    .DATA_W (DATA_W),
    .CHK_W  (CHK_W)
  ) u_enc (
    .data (wr_data),
    .chk  (wr_chk)
  );

  assign lo_wdata = wr_data[BANK_W-1:0];
  assign hi_wdata = {{PAD_W{1'b0}}, wr_chk, wr_data[DATA_W-1:BANK_W]};

  logic [BANK_W-1:0] lo_q;
  logic [HI_RD-1:0]  hi_q;

  ecc_ram_bank #(
    .DEPTH (DEPTH),
    .WIDTH (BANK_W),
    .RD_W  (BANK_W)
  ) u_bank_lo (
    .clk     (clk),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (lo_wdata),
    .rd_en   (rd_en),
    .rd_addr (rd_addr),
    .rd_data (lo_q)
  );

  // Upper bank keeps its padding bits in storage but never reads them out.
  ecc_ram_bank #(
    .DEPTH (DEPTH),
    .WIDTH (BANK_W),
    .RD_W  (HI_RD)
  ) u_bank_hi (
    .clk     (clk),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (hi_wdata),
    .rd_en   (rd_en),
    .rd_addr (rd_addr),
    .rd_data (hi_q)
  );

  // Read-valid tracking.
  logic rd_valid_q;
  logic rd_valid_d;

  always_comb begin
    rd_valid_d = rd_en;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      rd_valid_q <= 1'b0;
    end else begin
      rd_valid_q <= rd_valid_d;
    end
  end

  // Read path: unpack and correct.
  logic [DATA_W-1:0] raw_data;
  logic [CHK_W-1:0]  raw_chk;

  assign raw_data = {hi_q[HI_DW-1:0], lo_q};
  assign raw_chk  = hi_q[HI_DW +: CHK_W];

  ecc_ram_decoder #(
    .DATA_W (DATA_W),
    .CHK_W  (CHK_W)
  ) u_dec (
    .valid      (rd_valid_q),
    .raw_data   (raw_data),
    .raw_chk    (raw_chk),
    .fixed_data (rd_data),
    .alarm      (err_alarm),
    .fix        (err_fix),
    .fatal      (err_fatal)
  );

  assign rd_valid = rd_valid_q;

endmodule

// File: rtl/ecc_ram_checker.sv
module ecc_ram_checker #(
  parameter int unsigned DATA_W = 119
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rd_en,
  input logic              rd_valid,
  input logic [DATA_W-1:0] rd_data,
  input logic [DATA_W-1:0] raw_data,
  input logic              err_alarm,
  input logic              err_fix,
  input logic              err_fatal
);

  assert_rd_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rd_valid);

  assert_no_spurious_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> !rd_valid);

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_valid |-> !(err_alarm || err_fix || err_fatal));

  assert_class_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
    err_fix |-> !err_fatal);

  assert_alarm_cover_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (err_fix || err_fatal) |-> err_alarm);

  assert_alarm_classed_R5: assert property (@(posedge clk) disable iff (!rst_n)
    err_alarm |-> (err_fix || err_fatal));

  assert_clean_pass_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !err_alarm) |-> (rd_data == raw_data));

  assert_fatal_pass_R8: assert property (@(posedge clk) disable iff (!rst_n)
    err_fatal |-> (rd_data == raw_data));

  assert_fix_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    err_fix |-> ($countones(rd_data ^ raw_data) <= 1));

endmodule

bind ecc_ram_wrapper ecc_ram_checker #(
  .DATA_W (DATA_W)
) u_ecc_ram_checker (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .rd_en     (rd_en),
  .rd_valid  (rd_valid),
  .rd_data   (rd_data),
  .raw_data  (raw_data),
  .err_alarm (err_alarm),
  .err_fix   (err_fix),
  .err_fatal (err_fatal)
);

// File: tb/tb_ecc_ram_wrapper.sv
`timescale 1ns/1ps
module tb_ecc_ram_wrapper;

  localparam int DW = 119;
  localparam int AW = 5;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          wr_en;
  logic [AW-1:0] wr_addr;
  logic [DW-1:0] wr_data;
  logic          rd_en;
  logic [AW-1:0] rd_addr;
  logic [DW-1:0] rd_data;
  logic          rd_valid;
  logic          err_alarm;
  logic          err_fix;
  logic          err_fatal;

  always #2 clk = ~clk;

  ecc_ram_wrapper dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .rd_en     (rd_en),
    .rd_addr   (rd_addr),
    .rd_data   (rd_data),
    .rd_valid  (rd_valid),
    .err_alarm (err_alarm),
    .err_fix   (err_fix),
    .err_fatal (err_fatal)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;

  logic [DW-1:0] shadow [32];

  // Scoreboard queues; flags packed as {alarm, fix, fatal}.
  logic [DW-1:0] q_data [$];
  logic [2:0]    q_flags [$];
  string         q_tag [$];

  function automatic logic [DW-1:0] pattern(input int i);
    logic [127:0] w;
    w = {32'h9E3779B9 * (i + 1), 32'h85EBCA6B ^ (i * 7919),
         32'hC2B2AE35 + (i << 5), 32'h27D4EB2F * (i + 3)};
    return w[DW-1:0];
  endfunction

  // Data index of a non-check code position.
  function automatic int data_idx(input int p);
    int lg;
    lg = 0;
    while ((1 << (lg + 1)) <= p) lg++;
    return p - lg - 2;
  endfunction

  function automatic bit is_pow2(input int p);
    return (p & (p - 1)) == 0;
  endfunction

  task automatic check(input bit ok, input string req, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Invert one code position of a stored word, using the bank layout of R10.
  task automatic flip_pos(input int a, input int p);
    int j;
    int b;
    if (is_pow2(p)) begin
      b = 55;
      for (int k = 0; k < 7; k++) if ((1 << k) == p) b = 55 + k;
      dut.u_bank_hi.mem[a][b] = ~dut.u_bank_hi.mem[a][b];
    end else begin
      j = data_idx(p);
      if (j < 64) dut.u_bank_lo.mem[a][j] = ~dut.u_bank_lo.mem[a][j];
      else        dut.u_bank_hi.mem[a][j-64] = ~dut.u_bank_hi.mem[a][j-64];
    end
  endtask

  task automatic flip_pad(input int a, input int b);
    dut.u_bank_hi.mem[a][b] = ~dut.u_bank_hi.mem[a][b];
  endtask

  task automatic do_write(input int a, input logic [DW-1:0] d);
    wr_en = 1'b1; wr_addr = AW'(a); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
    shadow[a] = d;
  endtask

  task automatic do_read(input int a, input logic [DW-1:0] ed, input logic [2:0] ef,
                         input string tag);
    q_data.push_back(ed); q_flags.push_back(ef); q_tag.push_back(tag);
    rd_en = 1'b1; rd_addr = AW'(a);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic do_rw(input int a, input logic [DW-1:0] d, input string tag);
    q_data.push_back(shadow[a]); q_flags.push_back(3'b000); q_tag.push_back(tag);
    rd_en = 1'b1; rd_addr = AW'(a);
    wr_en = 1'b1; wr_addr = AW'(a); wr_data = d;
    @(negedge clk);
    rd_en = 1'b0; wr_en = 1'b0;
    shadow[a] = d;
  endtask

  // Monitor: pops one expected item per valid result.
  always @(negedge clk) begin
    if (rst_n && rd_valid) begin
      if (q_tag.size() == 0) begin
        check(1'b0, "R2 unexpected rd_valid", 1, 0);
      end else begin
        string         t;
        logic [DW-1:0] ed;
        logic [2:0]    ef;
        t = q_tag.pop_front(); ed = q_data.pop_front(); ef = q_flags.pop_front();
        check(rd_data == ed, {t, " data"}, rd_data, ed);
        check({err_alarm, err_fix, err_fatal} == ef, {t, " flags"},
              DW'({err_alarm, err_fix, err_fatal}), DW'(ef));
      end
    end
  end

  task automatic check_idle(input string tag);
    check(rd_valid == 1'b0, {tag, " rd_valid"}, DW'(rd_valid), 0);
    check({err_alarm, err_fix, err_fatal} == 3'b000, {tag, " flags"},
          DW'({err_alarm, err_fix, err_fatal}), 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] d;
    rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0;
    wr_addr = '0; rd_addr = '0; wr_data = '0;
    repeat (4) @(negedge clk);
    check_idle("R1 in reset");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check_idle("R1 after release");

    // R3: several patterns, written then read back to back (R2).
    do_write(0, '0);
    do_write(1, {DW{1'b1}});
    do_write(2, {60{2'b10}});
    for (int i = 3; i < 16; i++) do_write(i, pattern(i));
    do_write(16, DW'(1) << 118);
    for (int i = 0; i < 17; i++) do_read(i, shadow[i], 3'b000, "R3 clean readback");
    @(negedge clk);
    @(negedge clk);
    check(q_tag.size() == 0, "R2 result count", DW'(q_tag.size()), 0);
    check_idle("R2 idle after reads");

    // R11: write port active without wr_en.
    wr_en = 1'b0; wr_addr = 5'd1; wr_data = pattern(99);
    @(negedge clk);
    wr_data = '0;
    do_read(1, shadow[1], 3'b000, "R11 no write without enable");

    // R4: same-address read and write in one cycle.
    do_rw(2, pattern(50), "R4 read-before-write old word");
    do_read(2, shadow[2], 3'b000, "R4 new word visible");

    // R5: single data-bit flips.
    flip_pos(3, 3);
    do_read(3, shadow[3], 3'b110, "R5 flip at position 3");
    flip_pos(4, 126);
    do_read(4, shadow[4], 3'b110, "R5 flip at position 126");
    flip_pos(5, 100);
    do_read(5, shadow[5], 3'b110, "R5 flip at position 100");

    // R6: check-bit flips.
    flip_pos(6, 64);
    do_read(6, shadow[6], 3'b110, "R6 flip of check bit 6");
    flip_pos(7, 1);
    do_read(7, shadow[7], 3'b110, "R6 flip of check bit 0");

    // R7: padding bits.
    flip_pad(8, 62);
    flip_pad(8, 63);
    do_read(8, shadow[8], 3'b000, "R7 padding flips ignored");

    // R8: syndrome 127 from positions 63 and 64.
    flip_pos(9, 63);
    flip_pos(9, 64);
    d = shadow[9];
    d[data_idx(63)] = ~d[data_idx(63)];
    do_read(9, d, 3'b101, "R8 uncorrectable passes raw data");

    // R9: positions 3 and 5 miscorrect position 6.
    flip_pos(10, 3);
    flip_pos(10, 5);
    d = shadow[10] ^ DW'(3'b111);
    do_read(10, d, 3'b110, "R9 double error miscorrected");

    // R10: either side of the bank boundary (data bits 63 and 64).
    flip_pos(11, 71);
    do_read(11, shadow[11], 3'b110, "R10 lower bank top bit");
    flip_pos(12, 72);
    do_read(12, shadow[12], 3'b110, "R10 upper bank bottom bit");

    @(negedge clk);
    @(negedge clk);
    check(q_tag.size() == 0, "R2 final result count", DW'(q_tag.size()), 0);
    check_idle("R2 final idle");

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule